// File: doc/BRIEF.md
# Shadowed PWM Compare Channel

This block is one compare channel of a PWM generator. It holds a 16-bit compare value that software programs through a plain write strobe and reads back through a combinational read port. An external time-base counter is compared against the active compare value on every clock. When the two become equal, the channel raises a one-cycle compare event. Each of the two PWM outputs, A and B, then applies its own configured action to that event.

A mode input selects how software writes land. In buffered mode, a write goes to a shadow copy and sets a pending flag. The shadow is copied to the active value on a load strobe chosen by a 2-bit selector, which picks counter-at-zero, counter-at-period, either of them, or never. In direct mode, a write goes straight to the active value. Both copies sit behind the same single register port, and the mode decides which one is reached.

The counter, the zero strobe and the period strobe are inputs from a time base that is not part of this block. None of the interfaces carries a stream, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or status.

Top module: `pwm_cmp_chan`

## Requirements
- R1: After reset, the active and shadow values are 0, `shadow_full` is 0, `pwm_a` and `pwm_b` are 0, and with `direct_mode` at 0 `rd_data` reads 0.
- R2: With `direct_mode`=0, a write stores `wr_data` in the shadow. From the next cycle `rd_data` returns the shadow. The active value does not change until a load strobe.
- R3: With `direct_mode`=0, a write sets `shadow_full` on the next cycle. A load without a write clears it on the next cycle. When a write and a load fall in the same cycle, the active value takes the old shadow and `shadow_full` stays 1.
- R4: `load_sel` chooses when the shadow is copied to the active value: 2'b00 on `tb_zero`, 2'b01 on `tb_period`, 2'b10 on either strobe, 2'b11 never.
- R5: With `direct_mode`=1, a write stores `wr_data` in the active value, and `rd_data` returns the active value. Load strobes copy nothing, and `shadow_full` and the shadow keep their values.
- R6: `cmp_evt` is high only in the first cycle in which `tb_cnt` equals the active value. It stays low while the equality holds on in later cycles. Its state in the previous cycle resets to "not equal".
- R7: Each output has its own 2-bit action: 00 do nothing, 01 drive low, 10 drive high, 11 invert. The new level appears on the clock edge that ends the event cycle.
- R8: In a cycle with no compare event, `pwm_a` and `pwm_b` keep their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Compare value to write |
| rd_data | output | 16 | Shadow value (buffered mode) or active value (direct mode) |
| direct_mode | input | 1 | 0 writes through the shadow, 1 writes the active value directly |
| load_sel | input | 2 | Selects the shadow-to-active load strobe |
| act_a | input | 2 | Action applied to output A on a compare event |
| act_b | input | 2 | Action applied to output B on a compare event |
| tb_cnt | input | 16 | Time-base counter value |
| tb_zero | input | 1 | Counter-equals-zero strobe |
| tb_period | input | 1 | Counter-equals-period strobe |
| shadow_full | output | 1 | Shadow holds a value not yet loaded |
| cmp_evt | output | 1 | Compare event pulse |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The hardest cases to reach from the ports are a software write in the same cycle as a selected load strobe, and a counter held at the active value across several cycles. Random stimulus limits the counter to a few small values and drives each strobe often, so both cases come up many times. Directed sequences also set each of them up on purpose, alongside the frozen load selection and a mode switch with a value still pending in the shadow.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PERIOD = 2'b01,
    LD_EITHER = 2'b10,
    LD_FROZEN = 2'b11
  } ld_e;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:  apply_act = 1'b0;
      ACT_HIGH: apply_act = 1'b1;
      ACT_FLIP: apply_act = ~cur;
      default:  apply_act = cur;
    endcase
  endfunction

  function automatic logic load_hit(input ld_e sel, input logic zero, input logic prd);
    case (sel)
      LD_ZERO:   load_hit = zero;
      LD_PERIOD: load_hit = prd;
      LD_EITHER: load_hit = zero | prd;
      default:   load_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          direct_mode,
  input  logic [1:0]    load_sel,
  input  logic          tb_zero,
  input  logic          tb_period,
  output logic [CW-1:0] active_val,
  output logic [CW-1:0] rd_data,
  output logic          shadow_full
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] active_q;
  logic          full_q;
  logic          load_now;

  // Loads happen only in buffered mode.
  assign load_now = ~direct_mode & load_hit(ld_e'(load_sel), tb_zero, tb_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      full_q   <= 1'b0;
    end else if (direct_mode) begin
      if (wr_en) active_q <= wr_data;
    end else begin
      if (load_now) active_q <= shadow_q;
      if (wr_en) begin
        shadow_q <= wr_data;
        full_q   <= 1'b1;
      end else if (load_now) begin
        full_q   <= 1'b0;
      end
    end
  end

  assign active_val  = active_q;
  assign rd_data     = direct_mode ? active_q : shadow_q;
  assign shadow_full = full_q;
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tb_cnt,
  input  logic [CW-1:0] active_val,
  output logic          cmp_evt
);
  logic eq_now;
  logic eq_prev;

  assign eq_now = (tb_cnt == active_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_prev <= 1'b0;
    else        eq_prev <= eq_now;
  end

  assign cmp_evt = eq_now & ~eq_prev;
endmodule

// File: rtl/cmp_out.sv
module cmp_out
  import pwm_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic [1:0] act,
  output logic       pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pin <= 1'b0;
    else if (evt) pin <= apply_act(act_e'(act), pin);
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CW   = 16,
  parameter int NOUT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  input  logic          direct_mode,
  input  logic [1:0]    load_sel,
  input  logic [1:0]    act_a,
  input  logic [1:0]    act_b,
  input  logic [CW-1:0] tb_cnt,
  input  logic          tb_zero,
  input  logic          tb_period,
  output logic          shadow_full,
  output logic          cmp_evt,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int AW = 2 * NOUT;

  logic [CW-1:0]   cmp_active;
  logic [AW-1:0]   act_vec;
  logic [NOUT-1:0] pin_vec;

  cmp_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .direct_mode(direct_mode), .load_sel(load_sel),
    .tb_zero(tb_zero), .tb_period(tb_period),
    .active_val(cmp_active), .rd_data(rd_data), .shadow_full(shadow_full)
  );

  cmp_match #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt),
    .active_val(cmp_active), .cmp_evt(cmp_evt)
  );

  assign act_vec = {{(AW-4){1'b0}}, act_b, act_a};

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    cmp_out u_out (
      .clk(clk), .rst_n(rst_n), .evt(cmp_evt),
      .act(act_vec[2*i +: 2]), .pin(pin_vec[i])
    );
  end

  assign pwm_a = pin_vec[0];
  assign pwm_b = pin_vec[1];
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] rd_data,
  input logic          direct_mode,
  input logic [1:0]    act_a,
  input logic [CW-1:0] tb_cnt,
  input logic          shadow_full,
  input logic          cmp_evt,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic [CW-1:0] cmp_active
);
  // R3
  full_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !direct_mode) |=> shadow_full);

  // R5
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && direct_mode) |=> (cmp_active == $past(wr_data)));

  // R5
  direct_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |=> (shadow_full == $past(shadow_full)));

  // R6
  evt_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> (tb_cnt == cmp_active));

  // R6
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> !cmp_evt);

  // R7
  flip_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && act_a == 2'b11) |=> (pwm_a != $past(pwm_a)));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_evt |=> ($stable(pwm_a) && $stable(pwm_b)));
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .direct_mode(direct_mode), .act_a(act_a),
  .tb_cnt(tb_cnt), .shadow_full(shadow_full), .cmp_evt(cmp_evt),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .cmp_active(cmp_active)
);

// File: tb/pwm_cmp_chan_bench.sv
module pwm_cmp_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        direct_mode = 1'b0;
  logic [1:0]  load_sel = 2'b11;
  logic [1:0]  act_a = 2'b00;
  logic [1:0]  act_b = 2'b00;
  logic [15:0] tb_cnt = 16'h0100;
  logic        tb_zero = 1'b0;
  logic        tb_period = 1'b0;
  logic        shadow_full, cmp_evt, pwm_a, pwm_b;

  int vectors = 0;
  int errors  = 0;

  // model state
  logic [15:0] m_shadow = '0, m_active = '0;
  logic        m_full = 1'b0, m_eqp = 1'b0, m_a = 1'b0, m_b = 1'b0;

  pwm_cmp_chan u_pwm_cmp_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .direct_mode(direct_mode), .load_sel(load_sel), .act_a(act_a), .act_b(act_b),
    .tb_cnt(tb_cnt), .tb_zero(tb_zero), .tb_period(tb_period),
    .shadow_full(shadow_full), .cmp_evt(cmp_evt), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #4 clk = ~clk;

  function automatic logic f_act(input logic [1:0] a, input logic cur);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic f_load(input logic [1:0] s, input logic z, input logic p);
    case (s)
      2'b00:   return z;
      2'b01:   return p;
      2'b10:   return z | p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are already driven; check outputs mid-cycle, then step model and clock.
  task automatic step();
    logic evt, ld;
    #1;
    evt = (tb_cnt == m_active) && !m_eqp;
    chk("R6 cmp_evt", {15'b0, cmp_evt}, {15'b0, evt});
    chk(direct_mode ? "R5 rd_data" : "R2 rd_data", rd_data, direct_mode ? m_active : m_shadow);
    chk("R3 shadow_full", {15'b0, shadow_full}, {15'b0, m_full});
    chk("R7/R8 pwm_a", {15'b0, pwm_a}, {15'b0, m_a});
    chk("R7/R8 pwm_b", {15'b0, pwm_b}, {15'b0, m_b});
    ld = !direct_mode && f_load(load_sel, tb_zero, tb_period);
    m_eqp = (tb_cnt == m_active);
    if (evt) begin
      m_a = f_act(act_a, m_a);
      m_b = f_act(act_b, m_b);
    end
    if (direct_mode) begin
      if (wr_en) m_active = wr_data;
    end else begin
      if (ld) m_active = m_shadow;
      if (wr_en) begin m_shadow = wr_data; m_full = 1'b1; end
      else if (ld) m_full = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic [15:0] d, input logic dm,
                       input logic [1:0] ls, input logic [15:0] c,
                       input logic z, input logic p);
    wr_en = w; wr_data = d; direct_mode = dm; load_sel = ls;
    tb_cnt = c; tb_zero = z; tb_period = p;
    step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 shadow_full", {15'b0, shadow_full}, 16'h0);
    chk("R1 pwm_a", {15'b0, pwm_a}, 16'h0);
    chk("R1 pwm_b", {15'b0, pwm_b}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: buffered write then frozen load select (R4 11 never)
    drive(1, 16'h0005, 0, 2'b11, 16'h0100, 1, 1);
    drive(0, 16'h0000, 0, 2'b11, 16'h0005, 1, 1);   // no load: no match on 5
    // R4 00: period strobe alone does not load, zero strobe does
    drive(0, 16'h0000, 0, 2'b00, 16'h0100, 0, 1);
    drive(0, 16'h0000, 0, 2'b00, 16'h0100, 1, 0);
    act_a = 2'b10; act_b = 2'b11;
    // R6: held counter at match, only the first cycle fires (R7 set/toggle)
    drive(0, 16'h0000, 0, 2'b11, 16'h0005, 0, 0);
    drive(0, 16'h0000, 0, 2'b11, 16'h0005, 0, 0);
    drive(0, 16'h0000, 0, 2'b11, 16'h0005, 0, 0);
    // R3: write and load in same cycle: old shadow loaded, flag stays set
    drive(1, 16'h0009, 0, 2'b01, 16'h0100, 0, 0);
    drive(1, 16'h000A, 0, 2'b01, 16'h0100, 0, 1);
    drive(0, 16'h0000, 0, 2'b01, 16'h0009, 0, 0);
    // R4 10: either strobe loads
    drive(0, 16'h0000, 0, 2'b10, 16'h0100, 0, 1);
    act_a = 2'b01; act_b = 2'b00;
    drive(0, 16'h0000, 0, 2'b11, 16'h000A, 0, 0);
    // R5: direct mode with pending shadow, strobes copy nothing
    drive(1, 16'h0033, 0, 2'b10, 16'h0100, 0, 0);
    drive(1, 16'h0002, 1, 2'b10, 16'h0100, 1, 1);
    drive(0, 16'h0000, 1, 2'b10, 16'h0002, 1, 1);
    drive(0, 16'h0000, 0, 2'b11, 16'h0100, 0, 0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      act_a = 2'($urandom);
      act_b = 2'($urandom);
      drive(($urandom % 4) == 0, 16'($urandom % 6), ($urandom % 5) == 0,
            2'($urandom), 16'($urandom % 6),
            ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule